// File: doc/BRIEF.md
# Three-Slot Transmit Priority Scheduler

This block holds three outgoing message slots for a CAN-style controller and chooses which loaded slot the transmitter sends next. Software loads a slot's identifier, payload and an 8-bit local priority, then marks the slot ready. The transmitter pulses a request, and the scheduler locks the best ready slot and presents its contents. The transmitter then reports either a successful send or lost arbitration.

Three slots are the smallest number that keeps frames going back to back. One slot can be on the wire, a second can be waiting, and software can still reload the third. A request may arrive in the same cycle as the completion report, so the next frame is offered with no gap. The bus is released only when arbitration is lost with no new request, or when no slot is ready.

Each slot has a transmit-complete flag that raises the interrupt output. Software clears that flag by writing 1. Software can also abort a waiting slot that is not locked, and an acknowledge bit records the abort.

Top module: `tx_prio_sched`

## Requirements
- R1: After the asynchronous reset, ready_o, done_o, abort_ack_o, irq_o and tx_valid_o are all 0.
- R2: A write with wr_en_i stores the identifier, payload and priority into slot wr_slot_i, where slots are numbered 0 to 2. A 1 on bit i of rdy_set_i sets ready_o[i] one edge later and clears abort_ack_o[i].
- R3: A tx_req_i taken while no slot is locked selects the eligible ready slot with the lowest priority value. One edge later, tx_valid_o is 1 and tx_slot_o, tx_id_o and tx_data_o show that slot. A slot is eligible when it is ready and its abort_i bit is low.
- R4: When eligible slots have equal priority values, the lower slot index wins.
- R5: When a request finds no eligible slot, tx_valid_o stays 0.
- R6: While a slot is locked (tx_valid_o is 1 with tx_slot_o pointing at it), writes to it, rdy_set_i and abort_i bits for it, and further requests without a completion report have no effect. The presented slot and its contents stay stable.
- R7: When tx_ok_i is 1 while tx_valid_o is 1, the locked slot's ready bit clears and its done bit sets one edge later. Without a request in the same cycle, tx_valid_o drops to 0.
- R8: When tx_lost_i is 1 (and tx_ok_i is 0) while tx_valid_o is 1, the slot stays ready and is unlocked. Without a request in the same cycle, tx_valid_o drops to 0.
- R9: A tx_req_i in the same cycle as tx_ok_i or tx_lost_i is taken, so the next selection is presented one edge later with no idle cycle. A slot that completes successfully in that cycle is not eligible. A slot that lost arbitration is eligible again.
- R10: irq_o is the OR of done_o. A 1 on bit i of irq_clr_i clears done_o[i]. A completion in the same cycle takes precedence over the clear.
- R11: A 1 on bit i of abort_i for a ready, unlocked slot clears ready_o[i] and sets abort_ack_o[i]. An abort of a slot that is not ready has no effect.
- R12: Reloading an unlocked slot while another slot is transmitting leaves the transmitter outputs unchanged. The new contents are the ones sent when the reloaded slot is later selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for slot contents |
| wr_slot_i | input | SEL_W | Slot to write |
| wr_id_i | input | ID_W | Identifier to store |
| wr_data_i | input | DATA_W | Payload to store |
| wr_prio_i | input | PRIO_W | Local priority to store (lower value wins) |
| rdy_set_i | input | NSLOT | Per-slot ready set |
| abort_i | input | NSLOT | Per-slot abort request |
| irq_clr_i | input | NSLOT | Per-slot write-1 clear of the done flags |
| ready_o | output | NSLOT | Per-slot ready flags |
| done_o | output | NSLOT | Per-slot transmit-complete flags |
| abort_ack_o | output | NSLOT | Per-slot abort acknowledge |
| irq_o | output | 1 | OR of done flags |
| tx_req_i | input | 1 | Transmitter asks for the next message |
| tx_ok_i | input | 1 | Locked message was sent successfully |
| tx_lost_i | input | 1 | Locked message lost arbitration |
| tx_valid_o | output | 1 | A slot is locked and presented |
| tx_slot_o | output | SEL_W | Index of the presented slot |
| tx_id_o | output | ID_W | Identifier of the presented slot |
| tx_data_o | output | DATA_W | Payload of the presented slot |

## Verification
Every flag output (ready_o, done_o, abort_ack_o, and through them irq_o) changes on the first rising edge after the strobe that causes it. The transmitter outputs also settle on the first rising edge after a request, success or lost report. The bench drives all inputs just after a falling edge. It compares every output with a behavioural model at the next falling edge, which is exactly one rising edge after the stimulus. Directed checks sample in that same window, so each result is observed in the cycle it is due and is not seen early through a combinational path.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
  localparam int unsigned TX_SLOTS = 3;

  typedef enum logic [1:0] {
    END_NONE = 2'd0,
    END_OK   = 2'd1,
    END_LOST = 2'd2
  } tx_end_e;
endpackage

// File: rtl/tx_slot_store.sv
module tx_slot_store #(
  parameter int NSLOT  = 3,
  parameter int ID_W   = 29,
  parameter int DATA_W = 64,
  parameter int PRIO_W = 8,
  localparam int SEL_W = $clog2(NSLOT)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [SEL_W-1:0]                  wr_slot_i,
  input  logic [ID_W-1:0]                   wr_id_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  input  logic [PRIO_W-1:0]                 wr_prio_i,
  input  logic [NSLOT-1:0]                  rdy_set_i,
  input  logic [NSLOT-1:0]                  abort_i,
  input  logic [NSLOT-1:0]                  irq_clr_i,
  input  logic [NSLOT-1:0]                  lock_mask_i,
  input  logic [NSLOT-1:0]                  ok_mask_i,
  output logic [NSLOT-1:0]                  ready_o,
  output logic [NSLOT-1:0]                  done_o,
  output logic [NSLOT-1:0]                  ack_o,
  output logic [NSLOT-1:0][PRIO_W-1:0]      prio_o,
  output logic [NSLOT-1:0][ID_W-1:0]        id_o,
  output logic [NSLOT-1:0][DATA_W-1:0]      data_o
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic we, abort_hit, set_hit;

    assign we        = wr_en_i && (wr_slot_i == SEL_W'(i)) && !lock_mask_i[i];
    assign abort_hit = abort_i[i] && ready_o[i] && !lock_mask_i[i];
    assign set_hit   = rdy_set_i[i] && !lock_mask_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_o[i]   <= '0;
        data_o[i] <= '0;
        prio_o[i] <= '0;
      end else if (we) begin
        id_o[i]   <= wr_id_i;
        data_o[i] <= wr_data_i;
        prio_o[i] <= wr_prio_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ready_o[i] <= 1'b0;
        ack_o[i]   <= 1'b0;
      end else if (ok_mask_i[i]) begin
        ready_o[i] <= 1'b0;
      end else if (abort_hit) begin
        ready_o[i] <= 1'b0;
        ack_o[i]   <= 1'b1;
      end else if (set_hit) begin
        ready_o[i] <= 1'b1;
        ack_o[i]   <= 1'b0;
      end
    end

    // completion beats a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           done_o[i] <= 1'b0;
      else if (ok_mask_i[i]) done_o[i] <= 1'b1;
      else if (irq_clr_i[i]) done_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_prio_pick.sv
module tx_prio_pick #(
  parameter int NSLOT  = 3,
  parameter int PRIO_W = 8,
  localparam int SEL_W = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0]             elig_i,
  input  logic [NSLOT-1:0][PRIO_W-1:0] prio_i,
  output logic                         found_o,
  output logic [SEL_W-1:0]             idx_o
);
  logic [PRIO_W-1:0] best_prio;

  // strict compare keeps the lower index on ties
  always_comb begin
    found_o   = 1'b0;
    idx_o     = '0;
    best_prio = '1;
    for (int i = 0; i < NSLOT; i++) begin
      if (elig_i[i] && (!found_o || prio_i[i] < best_prio)) begin
        found_o   = 1'b1;
        idx_o     = SEL_W'(i);
        best_prio = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/tx_lock_ctrl.sv
module tx_lock_ctrl
  import tx_sched_pkg::*;
#(
  parameter int NSLOT  = 3,
  localparam int SEL_W = $clog2(NSLOT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             ok_i,
  input  logic             lost_i,
  input  logic             found_i,
  input  logic [SEL_W-1:0] pick_i,
  output logic             valid_o,
  output logic [SEL_W-1:0] slot_o,
  output logic [NSLOT-1:0] lock_mask_o,
  output logic [NSLOT-1:0] ok_mask_o
);
  tx_end_e end_kind;
  logic    ending, take;

  always_comb begin
    end_kind = END_NONE;
    if (valid_o) begin
      if (ok_i)        end_kind = END_OK;
      else if (lost_i) end_kind = END_LOST;
    end
  end

  assign ending = (end_kind != END_NONE);
  assign take   = req_i && found_i && (!valid_o || ending);

  for (genvar i = 0; i < NSLOT; i++) begin : g_mask
    assign lock_mask_o[i] = valid_o && (slot_o == SEL_W'(i));
    assign ok_mask_o[i]   = lock_mask_o[i] && (end_kind == END_OK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      slot_o  <= '0;
    end else if (take) begin
      valid_o <= 1'b1;
      slot_o  <= pick_i;
    end else if (ending) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_prio_sched.sv
module tx_prio_sched #(
  parameter int NSLOT  = tx_sched_pkg::TX_SLOTS,
  parameter int ID_W   = 29,
  parameter int DATA_W = 64,
  parameter int PRIO_W = 8,
  localparam int SEL_W = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_slot_i,
  input  logic [ID_W-1:0]   wr_id_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PRIO_W-1:0] wr_prio_i,
  input  logic [NSLOT-1:0]  rdy_set_i,
  input  logic [NSLOT-1:0]  abort_i,
  input  logic [NSLOT-1:0]  irq_clr_i,
  output logic [NSLOT-1:0]  ready_o,
  output logic [NSLOT-1:0]  done_o,
  output logic [NSLOT-1:0]  abort_ack_o,
  output logic              irq_o,
  input  logic              tx_req_i,
  input  logic              tx_ok_i,
  input  logic              tx_lost_i,
  output logic              tx_valid_o,
  output logic [SEL_W-1:0]  tx_slot_o,
  output logic [ID_W-1:0]   tx_id_o,
  output logic [DATA_W-1:0] tx_data_o
);
  logic [NSLOT-1:0]              lock_mask, ok_mask, elig;
  logic [NSLOT-1:0][PRIO_W-1:0]  prio;
  logic [NSLOT-1:0][ID_W-1:0]    ids;
  logic [NSLOT-1:0][DATA_W-1:0]  datas;
  logic                          found;
  logic [SEL_W-1:0]              pick;

  tx_slot_store #(
    .NSLOT(NSLOT), .ID_W(ID_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W)
  ) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_slot_i, .wr_id_i, .wr_data_i, .wr_prio_i,
    .rdy_set_i, .abort_i, .irq_clr_i,
    .lock_mask_i(lock_mask),
    .ok_mask_i  (ok_mask),
    .ready_o,
    .done_o,
    .ack_o      (abort_ack_o),
    .prio_o     (prio),
    .id_o       (ids),
    .data_o     (datas)
  );

  // a slot finishing successfully this cycle must not be re-picked
  assign elig = ready_o & ~abort_i & ~ok_mask;

  tx_prio_pick #(.NSLOT(NSLOT), .PRIO_W(PRIO_W)) u_pick (
    .elig_i (elig),
    .prio_i (prio),
    .found_o(found),
    .idx_o  (pick)
  );

  tx_lock_ctrl #(.NSLOT(NSLOT)) u_lock (
    .clk_i, .rst_ni,
    .req_i      (tx_req_i),
    .ok_i       (tx_ok_i),
    .lost_i     (tx_lost_i),
    .found_i    (found),
    .pick_i     (pick),
    .valid_o    (tx_valid_o),
    .slot_o     (tx_slot_o),
    .lock_mask_o(lock_mask),
    .ok_mask_o  (ok_mask)
  );

  assign tx_id_o   = ids[tx_slot_o];
  assign tx_data_o = datas[tx_slot_o];
  assign irq_o     = |done_o;
endmodule

// File: rtl/tx_prio_sched_chk.sv
module tx_prio_sched_chk #(
  parameter int NSLOT  = 3,
  parameter int ID_W   = 29,
  parameter int DATA_W = 64,
  localparam int SEL_W = $clog2(NSLOT)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSLOT-1:0]  abort_i,
  input logic [NSLOT-1:0]  ready_o,
  input logic [NSLOT-1:0]  done_o,
  input logic              tx_req_i,
  input logic              tx_ok_i,
  input logic              tx_lost_i,
  input logic              tx_valid_o,
  input logic [SEL_W-1:0]  tx_slot_o,
  input logic [ID_W-1:0]   tx_id_o,
  input logic [DATA_W-1:0] tx_data_o
);
  logic [SEL_W-1:0] slot_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= tx_slot_o;
  end

  AST_LOCKED_IS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> ready_o[tx_slot_o]); // R6

  AST_LOCK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ok_i && !tx_lost_i) |=>
      (tx_valid_o && $stable(tx_slot_o) && $stable(tx_id_o) && $stable(tx_data_o))); // R6

  AST_OK_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ok_i && !tx_req_i) |=> (!tx_valid_o && done_o[slot_q] && !ready_o[slot_q])); // R7

  AST_LOST_KEEPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_lost_i && !tx_ok_i) |=> ready_o[slot_q]); // R8

  AST_NO_IDLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_i && (!tx_valid_o || tx_lost_i) && |(ready_o & ~abort_i)) |=> tx_valid_o); // R9

  AST_EMPTY_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_valid_o && ready_o == '0) |=> !tx_valid_o); // R5
endmodule

bind tx_prio_sched tx_prio_sched_chk #(
  .NSLOT(NSLOT), .ID_W(ID_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tx_prio_sched_tb.sv
`timescale 1ns/1ps
module tx_prio_sched_tb_top;
  localparam int NS = 3;
  localparam int IW = 29;
  localparam int DW = 64;
  localparam int PW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_slot_i = '0;
  logic [IW-1:0] wr_id_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [PW-1:0] wr_prio_i = '0;
  logic [NS-1:0] rdy_set_i = '0, abort_i = '0, irq_clr_i = '0;
  logic [NS-1:0] ready_o, done_o, abort_ack_o;
  logic          irq_o;
  logic          tx_req_i = 1'b0, tx_ok_i = 1'b0, tx_lost_i = 1'b0;
  logic          tx_valid_o;
  logic [1:0]    tx_slot_o;
  logic [IW-1:0] tx_id_o;
  logic [DW-1:0] tx_data_o;

  always #2.5 clk_i = ~clk_i;

  tx_prio_sched dut_i (.*);

  int    n_run = 0, n_fail = 0;
  string phase = "R1";

  // behavioural reference
  bit            m_rdy[NS], m_done[NS], m_ack[NS];
  int            m_prio[NS];
  logic [IW-1:0] m_id[NS];
  logic [DW-1:0] m_data[NS];
  bit            m_lk;
  int            m_slot;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NS; i++) begin
        m_rdy[i] = 0; m_done[i] = 0; m_ack[i] = 0;
        m_prio[i] = 0; m_id[i] = '0; m_data[i] = '0;
      end
      m_lk = 0; m_slot = 0;
    end else begin
      automatic bit ok_e  = m_lk && tx_ok_i;
      automatic bit end_e = m_lk && (tx_ok_i || tx_lost_i);
      automatic int best  = -1;
      // search priority levels upward, slot order inside a level
      for (int p = 0; p < 256 && best < 0; p++)
        for (int i = 0; i < NS && best < 0; i++)
          if (m_rdy[i] && !abort_i[i] && !(ok_e && m_slot == i) && m_prio[i] == p)
            best = i;
      for (int i = 0; i < NS; i++) begin
        automatic bit lk_i = m_lk && m_slot == i;
        automatic bit ok_i = ok_e && m_slot == i;
        if (wr_en_i && wr_slot_i == i && !lk_i) begin
          m_id[i] = wr_id_i; m_data[i] = wr_data_i; m_prio[i] = wr_prio_i;
        end
        if (ok_i) begin m_rdy[i] = 0; m_done[i] = 1; end
        else begin
          if (irq_clr_i[i]) m_done[i] = 0;
          if (abort_i[i] && m_rdy[i] && !lk_i) begin m_rdy[i] = 0; m_ack[i] = 1; end
          else if (rdy_set_i[i] && !lk_i) begin m_rdy[i] = 1; m_ack[i] = 0; end
        end
      end
      if (tx_req_i && (!m_lk || end_e) && best >= 0) begin m_lk = 1; m_slot = best; end
      else if (end_e) m_lk = 0;
    end
  end

  function automatic logic [NS-1:0] pack3(bit a[NS]);
    return {a[2], a[1], a[0]};
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    automatic logic [NS-1:0] er = pack3(m_rdy), ed = pack3(m_done), ea = pack3(m_ack);
    automatic bit bad = (ready_o !== er) || (done_o !== ed) || (abort_ack_o !== ea) ||
                        (irq_o !== |ed) || (tx_valid_o !== m_lk);
    if (!bad && m_lk)
      bad = (tx_slot_o !== 2'(m_slot)) || (tx_id_o !== m_id[m_slot]) ||
            (tx_data_o !== m_data[m_slot]);
    n_run++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s model: actual rdy=%b done=%b ack=%b irq=%b v=%b s=%0d id=%0h expected rdy=%b done=%b ack=%b v=%b s=%0d id=%0h",
               phase, ready_o, done_o, abort_ack_o, irq_o, tx_valid_o, tx_slot_o, tx_id_o,
               er, ed, ea, m_lk, m_slot, m_id[m_slot]);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
    wr_en_i = 0; rdy_set_i = '0; abort_i = '0; irq_clr_i = '0;
    tx_req_i = 0; tx_ok_i = 0; tx_lost_i = 0;
  endtask

  task automatic load(int s, logic [IW-1:0] id, logic [DW-1:0] d, int p);
    wr_en_i = 1; wr_slot_i = 2'(s); wr_id_i = id; wr_data_i = d; wr_prio_i = 8'(p);
    step();
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 ready", ready_o, 0); chk("R1 done", done_o, 0);
    chk("R1 ack", abort_ack_o, 0); chk("R1 valid", tx_valid_o, 0);
    rst_ni = 1;

    phase = "R2";
    load(0, 29'h100, 64'hA0A0, 40);
    load(1, 29'h200, 64'hB0B0, 10);
    load(2, 29'h300, 64'hC0C0, 10);
    rdy_set_i = 3'b111; step();
    chk("R2 ready", ready_o, 3'b111);

    phase = "R3"; tx_req_i = 1; step();
    chk("R3 valid", tx_valid_o, 1);
    chk("R4 tie to lower index", tx_slot_o, 1);
    chk("R3 id", tx_id_o, 29'h200);

    phase = "R6";
    wr_en_i = 1; wr_slot_i = 1; wr_id_i = 29'h2FF; wr_prio_i = 0;
    abort_i = 3'b010; tx_req_i = 1; step();
    chk("R6 ready kept", ready_o, 3'b111);
    chk("R6 no ack", abort_ack_o, 0);
    chk("R6 id stable", tx_id_o, 29'h200);

    phase = "R12";
    load(0, 29'h111, 64'hD0D0, 5);
    chk("R12 slot unchanged", tx_slot_o, 1);
    chk("R12 id unchanged", tx_id_o, 29'h200);

    phase = "R9"; tx_ok_i = 1; tx_req_i = 1; step();
    chk("R9 no gap", tx_valid_o, 1);
    chk("R9 next slot", tx_slot_o, 0);
    chk("R12 new id sent", tx_id_o, 29'h111);
    chk("R7 done", done_o, 3'b010);
    chk("R7 ready", ready_o, 3'b101);
    chk("R10 irq", irq_o, 1);

    phase = "R8"; tx_lost_i = 1; tx_req_i = 1; step();
    chk("R8 reselected", tx_slot_o, 0);
    tx_lost_i = 1; step();
    chk("R8 released", tx_valid_o, 0);
    chk("R8 still ready", ready_o, 3'b101);

    phase = "R11"; abort_i = 3'b001; step();
    chk("R11 ready", ready_o, 3'b100);
    chk("R11 ack", abort_ack_o, 3'b001);
    abort_i = 3'b010; step();
    chk("R11 idle abort ignored", abort_ack_o, 3'b001);

    phase = "R10"; irq_clr_i = 3'b010; step();
    chk("R10 cleared", done_o, 0);
    chk("R10 irq low", irq_o, 0);

    phase = "R7"; tx_req_i = 1; step();
    chk("R3 only slot", tx_slot_o, 2);
    tx_ok_i = 1; irq_clr_i = 3'b100; step();
    chk("R7 valid drops", tx_valid_o, 0);
    chk("R10 set beats clear", done_o, 3'b100);

    phase = "R5"; tx_req_i = 1; step();
    chk("R5 nothing ready", tx_valid_o, 0);

    phase = "R2"; rdy_set_i = 3'b001; step();
    chk("R2 ack cleared", abort_ack_o, 0);
    chk("R2 ready", ready_o, 3'b001);
    step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule